// File: doc/BRIEF.md
# Configuration Request Intercept Controller

This block sits next to the configuration-intercept port of a PCIe endpoint controller. It holds every configuration request until it has decided what to do with it. It then lets the request go by dropping its halt output for one clock. In that same clock it can present a replacement word: for a write this word replaces the payload, and for a read it replaces the completion data.

The controller names each request by a 10-bit doubleword index, which is the byte offset divided by four. A small table, set by parameters, lists the addresses to match. Each entry gives an index, a direction, a value and a bit mask. The default table does two things:

- It rewrites the capabilities pointer, and the word at offset 0x60, so that a Vital Product Data capability appears in the capability chain.
- It rewrites writes to the device control word, so that the maximum payload size is forced to 128 bytes.

A write entry with a partial mask keeps the host's other bits and replaces only the masked field. Requests that arrive while a release is under way are held in a one-deep slot and released in turn.

Top module: `cfg_intercept_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, halt_o is 1, ovr_en_o is 0, ovr_data_o is 0 and no request is held.
- R2: A strobe sampled while idle, with nothing held, drives halt_o low in the next cycle for exactly one cycle. halt_o then returns high.
- R3: ovr_en_o is high only in a cycle where halt_o is low. ovr_data_o is zero in every cycle where ovr_en_o is low.
- R4: A read (cfg_wr_i = 0) of index 0x00D, which is byte offset 0x34, releases with ovr_en_o = 1 and ovr_data_o = 0x0000_0060.
- R5: A read of index 0x018 (byte offset 0x60) releases with ovr_data_o = 0x0000_4003. This is capability ID 03h with the next pointer 0x40.
- R6: A write (cfg_wr_i = 1) to index 0x01E (byte offset 0x78) with a full mask releases with ovr_data_o = 0x0000_2910, so bits 7:5 are 000.
- R7: A request to any index not in the table, or in the other direction at a listed index, still releases for one cycle, but ovr_en_o is 0 and ovr_data_o is 0.
- R8: A strobe that arrives in a release cycle is held. It is released two cycles later, after one cycle of halt_o high, and uses its own address, direction and data. One further strobe may arrive in that high cycle and is held in the same way.
- R9: A write entry yields (cfg_wdata_i AND NOT mask) OR (value AND mask). A read entry yields its value. With a table of one write entry at 0x01E, value 0 and mask 0x0000_00E0, a write there returns the host data with bits 7:5 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_req_i | input | 1 | One-cycle strobe marking a new configuration request |
| cfg_wr_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | ADDR_W | Doubleword index (byte offset / 4) |
| cfg_wdata_i | input | DATA_W | Host write payload |
| halt_o | output | 1 | Holds the request while high; low for one release cycle |
| ovr_en_o | output | 1 | Replacement valid in the release cycle |
| ovr_data_o | output | DATA_W | Replacement payload or completion word |

## Verification
The bench sweeps every index in both directions and checks the release word of every request against table values it computes itself. A design that decoded byte offsets, or ignored the direction, would override the wrong words, including reads of the device control word. Back-to-back and triple strobes check the hold slot: a design without it drops the second request, and one that reuses the old attributes returns the first request's word. A second instance with a partial mask shows whether write data is merged field by field or replaced whole.

// File: rtl/cfg_icpt_pkg.sv
package cfg_icpt_pkg;
   localparam int unsigned DFLT_ADDR_W = 10;
   localparam int unsigned DFLT_DATA_W = 32;

   typedef enum logic {
      PH_HOLD    = 1'b0,
      PH_RELEASE = 1'b1
   } phase_e;

   // Merge a fixed value into host data under a bit mask.
   function automatic logic [63:0] mask_merge(input logic [63:0] host,
                                              input logic [63:0] val,
                                              input logic [63:0] msk);
      return (host & ~msk) | (val & msk);
   endfunction
endpackage

// File: rtl/cfg_icpt_match.sv
module cfg_icpt_match #(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_ENT = 3,
   parameter logic [NUM_ENT-1:0][ADDR_W-1:0] ENT_ADDR = '0,
   parameter logic [NUM_ENT-1:0]             ENT_WR   = '0,
   parameter logic [NUM_ENT-1:0][DATA_W-1:0] ENT_VAL  = '0,
   parameter logic [NUM_ENT-1:0][DATA_W-1:0] ENT_MASK = '1
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] data_o
);
   import cfg_icpt_pkg::*;

   logic [NUM_ENT-1:0]             hit_vec;
   logic [NUM_ENT-1:0][DATA_W-1:0] cand;

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      for (genvar j = 0; j < e; j++) begin : g_dup
         if (ENT_ADDR[e] == ENT_ADDR[j] && ENT_WR[e] == ENT_WR[j]) begin : g_bad
            $error("cfg_icpt_match: entries %0d and %0d collide", j, e);
         end
      end

      assign hit_vec[e] = (addr_i == ENT_ADDR[e]) && (wr_i == ENT_WR[e]);

      if (ENT_WR[e]) begin : g_wr
         logic [63:0] merged;
         assign merged  = mask_merge(64'(wdata_i), 64'(ENT_VAL[e]), 64'(ENT_MASK[e]));
         assign cand[e] = merged[DATA_W-1:0];
      end else begin : g_rd
         assign cand[e] = ENT_VAL[e];
      end
   end

   // Lowest entry wins; entries are kept disjoint by the check above.
   always_comb begin
      hit_o  = 1'b0;
      data_o = '0;
      for (int e = NUM_ENT - 1; e >= 0; e--) begin
         if (hit_vec[e]) begin
            hit_o  = 1'b1;
            data_o = cand[e];
         end
      end
   end
endmodule

// File: rtl/cfg_icpt_sched.sv
module cfg_icpt_sched #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              launch_o,
   output logic              sel_wr_o,
   output logic [ADDR_W-1:0] sel_addr_o,
   output logic [DATA_W-1:0] sel_wdata_o
);
   import cfg_icpt_pkg::*;

   phase_e            phase_q;
   logic              slot_v_q;
   logic              slot_wr_q;
   logic [ADDR_W-1:0] slot_addr_q;
   logic [DATA_W-1:0] slot_wdata_q;
   logic              capture;

   assign launch_o    = (phase_q == PH_HOLD) && (slot_v_q || req_i);
   assign sel_wr_o    = slot_v_q ? slot_wr_q    : wr_i;
   assign sel_addr_o  = slot_v_q ? slot_addr_q  : addr_i;
   assign sel_wdata_o = slot_v_q ? slot_wdata_q : wdata_i;
   assign capture     = req_i && ((phase_q == PH_RELEASE) || slot_v_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q      <= PH_HOLD;
         slot_v_q     <= 1'b0;
         slot_wr_q    <= 1'b0;
         slot_addr_q  <= '0;
         slot_wdata_q <= '0;
      end else begin
         phase_q <= launch_o ? PH_RELEASE : PH_HOLD;
         if (capture) begin
            slot_v_q     <= 1'b1;
            slot_wr_q    <= wr_i;
            slot_addr_q  <= addr_i;
            slot_wdata_q <= wdata_i;
         end else if (launch_o) begin
            slot_v_q <= 1'b0;
         end
      end
   end

   // R8
   slot_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_i && (phase_q == PH_RELEASE) && slot_v_q));
   // R8
   held_serviced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_v_q && phase_q == PH_HOLD) |=> (phase_q == PH_RELEASE));
   // R2
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && phase_q == PH_HOLD && !slot_v_q) |=> (phase_q == PH_RELEASE && !slot_v_q));
   // R2
   rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RELEASE) |=> (phase_q == PH_HOLD));
endmodule

// File: rtl/cfg_intercept_ctrl.sv
module cfg_intercept_ctrl #(
   parameter int unsigned ADDR_W  = cfg_icpt_pkg::DFLT_ADDR_W,
   parameter int unsigned DATA_W  = cfg_icpt_pkg::DFLT_DATA_W,
   parameter int unsigned NUM_ENT = 3,
   parameter logic [NUM_ENT-1:0][ADDR_W-1:0] ENT_ADDR = {10'h01E, 10'h018, 10'h00D},
   parameter logic [NUM_ENT-1:0]             ENT_WR   = 3'b100,
   parameter logic [NUM_ENT-1:0][DATA_W-1:0] ENT_VAL  = {32'h0000_2910, 32'h0000_4003, 32'h0000_0060},
   parameter logic [NUM_ENT-1:0][DATA_W-1:0] ENT_MASK = {3{32'hFFFF_FFFF}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_req_i,
   input  logic              cfg_wr_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic              halt_o,
   output logic              ovr_en_o,
   output logic [DATA_W-1:0] ovr_data_o
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("cfg_intercept_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 8 || DATA_W > 64) begin : g_bad_dw
      $error("cfg_intercept_ctrl: DATA_W out of range");
   end
   if (NUM_ENT < 1 || NUM_ENT > 32) begin : g_bad_ne
      $error("cfg_intercept_ctrl: NUM_ENT out of range");
   end

   logic              launch;
   logic              sel_wr;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   logic              hit;
   logic [DATA_W-1:0] mdata;

   cfg_icpt_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sched (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (cfg_req_i),
      .wr_i       (cfg_wr_i),
      .addr_i     (cfg_addr_i),
      .wdata_i    (cfg_wdata_i),
      .launch_o   (launch),
      .sel_wr_o   (sel_wr),
      .sel_addr_o (sel_addr),
      .sel_wdata_o(sel_wdata)
   );

   cfg_icpt_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ENT(NUM_ENT),
      .ENT_ADDR(ENT_ADDR), .ENT_WR(ENT_WR), .ENT_VAL(ENT_VAL), .ENT_MASK(ENT_MASK)
   ) u_match (
      .wr_i   (sel_wr),
      .addr_i (sel_addr),
      .wdata_i(sel_wdata),
      .hit_o  (hit),
      .data_o (mdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_o     <= 1'b1;
         ovr_en_o   <= 1'b0;
         ovr_data_o <= '0;
      end else begin
         halt_o     <= ~launch;
         ovr_en_o   <= launch & hit;
         ovr_data_o <= (launch & hit) ? mdata : '0;
      end
   end

   // R2
   halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !halt_o |=> halt_o);
   // R3
   ovr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en_o |-> !halt_o);
   // R3
   ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_en_o |-> (ovr_data_o == '0));
   // R8
   fwd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_i && !halt_o) |=> halt_o ##1 !halt_o);
endmodule

// File: tb/tb_cfg_intercept_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_intercept_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        wr = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        halt, en, c_halt, c_en;
   logic [31:0] data, c_data;
   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   cfg_intercept_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_req_i(req), .cfg_wr_i(wr),
      .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .halt_o(halt), .ovr_en_o(en), .ovr_data_o(data)
   );

   cfg_intercept_ctrl #(
      .NUM_ENT(1), .ENT_ADDR(10'h01E), .ENT_WR(1'b1),
      .ENT_VAL(32'h0), .ENT_MASK(32'h0000_00E0)
   ) u_clamp (
      .clk(clk), .rst_n(rst_n), .cfg_req_i(req), .cfg_wr_i(wr),
      .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .halt_o(c_halt), .ovr_en_o(c_en), .ovr_data_o(c_data)
   );

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [32:0] exp_main(input logic w, input logic [9:0] a);
      if (!w && a == 10'd13) return {1'b1, 32'h60};
      if (!w && a == 10'd24) return {1'b1, 32'h4003};
      if (w && a == 10'd30)  return {1'b1, 32'h2910};
      return 33'h0;
   endfunction

   function automatic string tag(input logic w, input logic [9:0] a);
      if (!w && a == 10'd13) return "R4";
      if (!w && a == 10'd24) return "R5";
      if (w && a == 10'd30)  return "R6";
      return "R7";
   endfunction

   task automatic drive(input logic w, input logic [9:0] a, input logic [31:0] d);
      req = 1'b1; wr = w; addr = a; wdata = d;
   endtask

   task automatic check_release(input logic w, input logic [9:0] a, input logic [31:0] d, input string rq);
      logic [32:0] e;
      e = exp_main(w, a);
      chk(halt == 1'b0, "R2 halt low", 64'(halt), 64'(0));
      chk({en, data} == e, rq, 64'({en, data}), 64'(e));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during and after reset
      chk({halt, en, data} == {1'b1, 1'b0, 32'h0}, "R1 in reset", 64'({halt, en, data}), 64'({1'b1, 33'h0}));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({halt, en, data} == {1'b1, 1'b0, 32'h0}, "R1 after reset", 64'({halt, en, data}), 64'({1'b1, 33'h0}));
      chk({c_halt, c_en, c_data} == {1'b1, 33'h0}, "R1 clamp", 64'({c_halt, c_en, c_data}), 64'({1'b1, 33'h0}));

      // Exhaustive sweep: every index, both directions (R2..R7, R9)
      for (int w = 0; w < 2; w++) begin
         for (int a = 0; a < 1024; a++) begin
            logic [31:0] d;
            logic        ce;
            logic [31:0] cd;
            d = {6'h2D, 10'(a), 6'h15, ~10'(a)};
            drive(w[0], 10'(a), d);
            @(negedge clk);
            check_release(w[0], 10'(a), d, tag(w[0], 10'(a)));
            ce = (w == 1) && (a == 30);
            cd = ce ? (d & ~32'h0000_00E0) : 32'h0;
            chk({c_halt, c_en, c_data} == {1'b0, ce, cd}, "R9 clamp merge",
                64'({c_halt, c_en, c_data}), 64'({1'b0, ce, cd}));
            req = 1'b0;
            @(negedge clk);
            chk({halt, en, data} == {1'b1, 33'h0}, "R3 idle after release",
                64'({halt, en, data}), 64'({1'b1, 33'h0}));
         end
      end

      // R9: clamp with all-ones and all-zeros host data
      drive(1'b1, 10'h01E, 32'hFFFF_FFFF);
      @(negedge clk);
      chk({c_en, c_data} == {1'b1, 32'hFFFF_FF1F}, "R9 ones", 64'({c_en, c_data}), 64'({1'b1, 32'hFFFF_FF1F}));
      req = 1'b0;
      @(negedge clk);
      drive(1'b1, 10'h01E, 32'h0);
      @(negedge clk);
      chk({c_en, c_data} == {1'b1, 32'h0}, "R9 zeros", 64'({c_en, c_data}), 64'({1'b1, 32'h0}));
      req = 1'b0;
      @(negedge clk);

      // R8: strobe during release, then another in the high cycle
      drive(1'b0, 10'h00D, 32'h0);
      @(negedge clk);
      check_release(1'b0, 10'h00D, 32'h0, "R8 first R4");
      drive(1'b1, 10'h01E, 32'h1234_5678);
      @(negedge clk);
      chk({halt, en, data} == {1'b1, 33'h0}, "R8 high gap", 64'({halt, en, data}), 64'({1'b1, 33'h0}));
      drive(1'b0, 10'h018, 32'h0);
      @(negedge clk);
      check_release(1'b1, 10'h01E, 32'h1234_5678, "R8 held write R6");
      chk({c_en, c_data} == {1'b1, 32'h1234_5618}, "R8 held clamp R9",
          64'({c_en, c_data}), 64'({1'b1, 32'h1234_5618}));
      req = 1'b0;
      @(negedge clk);
      chk(halt == 1'b1, "R8 second gap", 64'(halt), 64'(1));
      @(negedge clk);
      check_release(1'b0, 10'h018, 32'h0, "R8 held read R5");
      @(negedge clk);
      chk({halt, en, data} == {1'b1, 33'h0}, "R8 drained", 64'({halt, en, data}), 64'({1'b1, 33'h0}));
      repeat (3) @(negedge clk);
      chk(halt == 1'b1, "R2 no spurious release", 64'(halt), 64'(1));

      // R1: reset mid-run
      drive(1'b0, 10'h00D, 32'h0);
      rst_n = 1'b0;
      @(negedge clk);
      req = 1'b0;
      chk({halt, en, data} == {1'b1, 33'h0}, "R1 reset mid-run", 64'({halt, en, data}), 64'({1'b1, 33'h0}));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(halt == 1'b1, "R1 nothing held", 64'(halt), 64'(1));

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule